// File: doc/BRIEF.md
# Mode Register Write Sequencer

This block sits inside a DDR SDRAM controller and turns one request for a mode-register write into a correctly timed series of commands. A request names the target register (base or extended), gives the opcode to place on the address bus, and can ask for a DLL reset. When the request is accepted, the block samples the bank-open status. If any bank is open, it first issues a precharge-all command and waits out the row precharge time. It then issues the mode-register command.

After the mode-register command, the block stays busy for the minimum mode-register delay. A DLL-reset write adds a long lock-out on top of that delay, and no command of any kind may be issued during it. While the block is waiting, the command output is a no-operation. A new request is taken only when the block is not busy.

Refresh, the read and write data paths and power-up initialisation are handled elsewhere in the controller.

Top module: `mrs_timing_guard`

## Requirements
- R1: While reset is asserted and in the first cycle after it, busy is 0, cmdValid is 0 and cmd is NOP.
- R2: A request is accepted on a rising edge only when reqValid is 1 and busy is 0. Any request fields presented while busy is 1 have no effect on the sequence in progress, and busy rises in the cycle after an acceptance.
- R3: bankOpen is sampled at the acceptance edge. If any bit is set, the cycle after acceptance carries cmd PREALL (code 1) with cmdAddr bit 10 set, every other address bit 0, and cmdBank 0.
- R4: The mode command follows the precharge-all exactly TRP cycles later, and cmd is NOP in the cycles between them.
- R5: If no bank is open at acceptance, the mode command appears in the cycle right after acceptance and no precharge-all is issued.
- R6: The mode command has cmd code 2 (MODESET) and cmdAddr equal to the accepted opcode, passed unchanged; the low four bits carry burst length and burst type. cmdBank is 1 for the extended register and 0 for the base register.
- R7: Without a DLL reset, busy stays 1 up to the mode-command cycle plus TMRD minus 1 and is 0 in the cycle at mode-command plus TMRD.
- R8: With a DLL reset, busy stays 1 and no command is issued until the mode-command cycle plus TMRD plus DLL_LOCK. Busy is 0 in that cycle.
- R9: The command codes are NOP 0, PREALL 1 and MODESET 2. cmdValid is 1 exactly when cmd is not NOP, and every command lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe; taken only when busy is low |
| reqExt | input | 1 | 1 selects the extended mode register |
| reqOpcode | input | ADDR_W | Opcode placed on the address bus |
| reqDllReset | input | 1 | Request includes a DLL reset |
| bankOpen | input | NUM_BANKS | One bit per bank, set when the bank has an open row |
| busy | output | 1 | Sequence in progress |
| cmdValid | output | 1 | A real command is on cmd this cycle |
| cmd | output | 2 | Command code: 0 NOP, 1 PREALL, 2 MODESET |
| cmdAddr | output | ADDR_W | Address bus for the command |
| cmdBank | output | BANK_W | Bank address; selects base or extended register |

## Verification
Two events can fall in the same cycle: busy being released at the end of a wait, and a new request that was held pending through that wait. The bench provokes this by keeping reqValid high with different fields during a whole sequence, including a changed bank-open pattern and a DLL-reset flag. It judges the result in two ways. The first sequence must carry only its own opcode and timing. The held request must then start exactly on the edge after busy falls, and its precharge decision must follow the bank status at that edge.

// File: rtl/mrs_guard_pkg.sv
package mrs_guard_pkg;

  typedef enum logic [1:0] {
    CMD_NOP     = 2'd0,
    CMD_PREALL  = 2'd1,
    CMD_MODESET = 2'd2
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PRE   = 3'd1,
    ST_WRP   = 3'd2,
    ST_MODE  = 3'd3,
    ST_WMRD  = 3'd4,
    ST_WDLL  = 3'd5
  } state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;
    logic loadRp;
    logic loadMrd;
    logic loadDll;
    logic countDown;
    logic showPre;
    logic showMode;
  } strobe_t;

endpackage

// File: rtl/mrs_guard_ctrl.sv
module mrs_guard_ctrl
  import mrs_guard_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    anyOpen,
  input  logic    dllFlag,
  input  logic    cntOne,
  output strobe_t strobes,
  output logic    busy
);

  state_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobes   = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobes.accept = 1'b1;
          nextState = anyOpen ? ST_PRE : ST_MODE;
        end
      end
      ST_PRE: begin
        strobes.showPre = 1'b1;
        strobes.loadRp  = 1'b1;
        nextState = ST_WRP;
      end
      ST_WRP: begin
        if (cntOne) nextState = ST_MODE;
        else        strobes.countDown = 1'b1;
      end
      ST_MODE: begin
        strobes.showMode = 1'b1;
        strobes.loadMrd  = 1'b1;
        nextState = ST_WMRD;
      end
      ST_WMRD: begin
        if (cntOne) begin
          if (dllFlag) begin
            strobes.loadDll = 1'b1;
            nextState = ST_WDLL;
          end else begin
            nextState = ST_IDLE;
          end
        end else begin
          strobes.countDown = 1'b1;
        end
      end
      ST_WDLL: begin
        if (cntOne) nextState = ST_IDLE;
        else        strobes.countDown = 1'b1;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

  // R2: an acceptance always makes the block busy on the next cycle
  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid) |=> busy);

  // R3: a precharge-all is always followed by a precharge wait
  p_pre_then_wait_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PRE) |=> (state == ST_WRP));

  // R9: at most one load or count action per cycle
  p_strobe_onehot_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.loadRp, strobes.loadMrd, strobes.loadDll, strobes.countDown}));

endmodule

// File: rtl/mrs_guard_dp.sv
module mrs_guard_dp
  import mrs_guard_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int BANK_W      = 2,
  parameter int PRE_ALL_BIT = 10,
  parameter int TRP         = 3,
  parameter int TMRD        = 2,
  parameter int DLL_LOCK    = 200
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic              reqExt,
  input  logic [ADDR_W-1:0] reqOpcode,
  input  logic              reqDllReset,
  output logic              cntOne,
  output logic              dllFlag,
  output logic              cmdValid,
  output logic [1:0]        cmd,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [BANK_W-1:0] cmdBank
);

  localparam int MAX_WAIT = (DLL_LOCK > TRP) ? ((DLL_LOCK > TMRD) ? DLL_LOCK : TMRD)
                                             : ((TRP > TMRD) ? TRP : TMRD);
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);
  localparam logic [CNT_W-1:0] RP_LOAD  = CNT_W'((TRP  > 1) ? TRP  - 1 : 1);
  localparam logic [CNT_W-1:0] MRD_LOAD = CNT_W'((TMRD > 1) ? TMRD - 1 : 1);
  localparam logic [CNT_W-1:0] DLL_LOAD = CNT_W'((DLL_LOCK > 0) ? DLL_LOCK : 1);
  localparam logic [ADDR_W-1:0] PRE_ADDR = ADDR_W'(1) << PRE_ALL_BIT;

  logic [ADDR_W-1:0] opLatch;
  logic              extLatch;
  logic              dllLatch;
  logic [CNT_W-1:0]  waitCnt;
  cmd_e              cmdSel;

  // request capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      opLatch  <= '0;
      extLatch <= 1'b0;
      dllLatch <= 1'b0;
    end else if (strobes.accept) begin
      opLatch  <= reqOpcode;
      extLatch <= reqExt;
      dllLatch <= reqDllReset;
    end
  end

  // wait counter
  always_ff @(posedge clk) begin
    if (!rstN)                  waitCnt <= '0;
    else if (strobes.loadRp)    waitCnt <= RP_LOAD;
    else if (strobes.loadMrd)   waitCnt <= MRD_LOAD;
    else if (strobes.loadDll)   waitCnt <= DLL_LOAD;
    else if (strobes.countDown) waitCnt <= waitCnt - 1'b1;
  end

  assign cntOne  = (waitCnt == CNT_W'(1));
  assign dllFlag = dllLatch;

  // command output mux
  always_comb begin
    cmdSel  = CMD_NOP;
    cmdAddr = '0;
    cmdBank = '0;
    if (strobes.showMode) begin
      cmdSel  = CMD_MODESET;
      cmdAddr = opLatch;
      cmdBank = BANK_W'(extLatch);
    end else if (strobes.showPre) begin
      cmdSel  = CMD_PREALL;
      cmdAddr = PRE_ADDR;
    end
  end

  assign cmd      = cmdSel;
  assign cmdValid = (cmdSel != CMD_NOP);

  // R4: the counter never wraps below one while counting
  p_count_positive_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.countDown |-> (waitCnt > CNT_W'(1)));

  // R2: latched request is frozen outside acceptance
  p_latch_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.accept |=> ($stable(opLatch) && $stable(extLatch) && $stable(dllLatch)));

endmodule

// File: rtl/mrs_timing_guard.sv
module mrs_timing_guard
  import mrs_guard_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int BANK_W      = 2,
  parameter int NUM_BANKS   = 4,
  parameter int PRE_ALL_BIT = 10,
  parameter int TRP         = 3,
  parameter int TMRD        = 2,
  parameter int DLL_LOCK    = 200
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqExt,
  input  logic [ADDR_W-1:0]    reqOpcode,
  input  logic                 reqDllReset,
  input  logic [NUM_BANKS-1:0] bankOpen,
  output logic                 busy,
  output logic                 cmdValid,
  output logic [1:0]           cmd,
  output logic [ADDR_W-1:0]    cmdAddr,
  output logic [BANK_W-1:0]    cmdBank
);

  strobe_t strobes;
  logic    cntOne;
  logic    dllFlag;

  mrs_guard_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .anyOpen (|bankOpen),
    .dllFlag (dllFlag),
    .cntOne  (cntOne),
    .strobes (strobes),
    .busy    (busy)
  );

  mrs_guard_dp #(
    .ADDR_W     (ADDR_W),
    .BANK_W     (BANK_W),
    .PRE_ALL_BIT(PRE_ALL_BIT),
    .TRP        (TRP),
    .TMRD       (TMRD),
    .DLL_LOCK   (DLL_LOCK)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .reqExt     (reqExt),
    .reqOpcode  (reqOpcode),
    .reqDllReset(reqDllReset),
    .cntOne     (cntOne),
    .dllFlag    (dllFlag),
    .cmdValid   (cmdValid),
    .cmd        (cmd),
    .cmdAddr    (cmdAddr),
    .cmdBank    (cmdBank)
  );

  // command spacing monitor
  localparam int GAP_MAX = TRP + TMRD + DLL_LOCK + 2;
  localparam int GAP_W   = $clog2(GAP_MAX + 1);

  logic [GAP_W-1:0] gapCnt;
  logic [1:0]       lastKind; // 0 none, 1 precharge, 2 mode, 3 mode with DLL reset

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapCnt   <= '0;
      lastKind <= 2'd0;
    end else begin
      if (cmdValid) begin
        gapCnt   <= GAP_W'(1);
        lastKind <= (cmd == CMD_PREALL) ? 2'd1 : (dllFlag ? 2'd3 : 2'd2);
      end else if (gapCnt != GAP_W'(GAP_MAX)) begin
        gapCnt <= gapCnt + 1'b1;
      end
    end
  end

  // R4: mode command lands exactly TRP cycles after the precharge
  p_rp_exact_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_MODESET && lastKind == 2'd1) |-> (gapCnt == GAP_W'(TRP)));

  // R7: minimum mode-register delay before any later command
  p_mrd_gap_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && lastKind == 2'd2) |-> (gapCnt > GAP_W'(TMRD)));

  // R8: DLL lock-out before any later command
  p_dll_gap_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && lastKind == 2'd3) |-> (gapCnt > GAP_W'(TMRD + DLL_LOCK)));

  // R9: each command lasts a single cycle
  p_cmd_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);

  // R2: nothing is issued while idle
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !cmdValid);

endmodule

// File: tb/sim_mrs_timing_guard.sv
module sim_mrs_timing_guard;

  localparam int ADDR_W   = 13;
  localparam int BANK_W   = 2;
  localparam int NB       = 4;
  localparam int TRP      = 3;
  localparam int TMRD     = 2;
  localparam int DLL_LOCK = 200;

  typedef struct packed {
    int                cyc;
    int                tag;
    logic [1:0]        code;
    logic [ADDR_W-1:0] addr;
    logic [BANK_W-1:0] bank;
  } exp_t;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqExt = 1'b0;
  logic [ADDR_W-1:0] reqOpcode = '0;
  logic              reqDllReset = 1'b0;
  logic [NB-1:0]     bankOpen = '0;
  logic              busy;
  logic              cmdValid;
  logic [1:0]        cmd;
  logic [ADDR_W-1:0] cmdAddr;
  logic [BANK_W-1:0] cmdBank;

  int   cyc = 0;
  int   checks = 0;
  int   failures = 0;
  bit   monOn = 1'b0;
  bit   finished = 1'b0;
  exp_t expQ[$];

  always #10 clk = ~clk; // 50 MHz

  always @(posedge clk) cyc <= cyc + 1;

  mrs_timing_guard #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .NUM_BANKS(NB),
    .TRP(TRP), .TMRD(TMRD), .DLL_LOCK(DLL_LOCK)
  ) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqExt(reqExt),
    .reqOpcode(reqOpcode), .reqDllReset(reqDllReset), .bankOpen(bankOpen),
    .busy(busy), .cmdValid(cmdValid), .cmd(cmd), .cmdAddr(cmdAddr), .cmdBank(cmdBank)
  );

  task automatic note(input bit ok, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", what, act, expv, cyc);
    end
  endtask

  // monitor: compares every issued command against the scoreboard (R3 R4 R5 R6 R9)
  always @(negedge clk) begin
    if (monOn) begin
      if (cmdValid != (cmd != 2'd0)) begin
        failures++;
        $display("FAIL R9 cmdValid=%0d with cmd=%0d expected valid=%0d", cmdValid, cmd, cmd != 2'd0);
      end
      if (cmdValid || cmd != 2'd0) begin
        if (expQ.size() == 0) begin
          note(1'b0, "R2 unexpected command", cmd, 0);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          note(cyc == e.cyc, $sformatf("R%0d command cycle", e.tag), cyc, e.cyc);
          note(cmd == e.code, $sformatf("R%0d command code", e.tag), cmd, e.code);
          note(cmdAddr == e.addr, $sformatf("R%0d address", e.tag), cmdAddr, e.addr);
          note(cmdBank == e.bank, $sformatf("R%0d bank", e.tag), cmdBank, e.bank);
        end
      end else if (expQ.size() != 0 && cyc > expQ[0].cyc) begin
        note(1'b0, $sformatf("R%0d missing command", expQ[0].tag), 0, expQ[0].cyc);
        void'(expQ.pop_front());
      end
    end
  end

  // present a request at the current negedge; returns the cycle in which busy must be low
  task automatic present(input bit ext, input logic [ADDR_W-1:0] op, input bit dll,
                         input logic [NB-1:0] open, output int freeCyc, output int modeCyc);
    int c;
    c = cyc;
    reqValid = 1'b1; reqExt = ext; reqOpcode = op; reqDllReset = dll; bankOpen = open;
    if (open != '0) begin
      // R3 precharge-all with address bit 10
      expQ.push_back('{cyc: c + 1, tag: 3, code: 2'd1, addr: ADDR_W'(1) << 10, bank: '0});
      modeCyc = c + 1 + TRP; // R4
    end else begin
      modeCyc = c + 1;       // R5
    end
    expQ.push_back('{cyc: modeCyc, tag: 6, code: 2'd2, addr: op, bank: BANK_W'(ext)});
    freeCyc = modeCyc + TMRD + (dll ? DLL_LOCK : 0);
  endtask

  // wait out a sequence, checking busy each cycle (R7 R8)
  task automatic waitFree(input int freeCyc, input bit dll);
    while (cyc < freeCyc) begin
      if (busy !== 1'b1) note(1'b0, dll ? "R8 busy during lock-out" : "R7 busy during wait", busy, 1);
      @(negedge clk);
    end
    note(busy === 1'b0, dll ? "R8 busy released" : "R7 busy released", busy, 0);
  endtask

  task automatic runOne(input bit ext, input logic [ADDR_W-1:0] op, input bit dll,
                        input logic [NB-1:0] open);
    int f, m;
    present(ext, op, dll, open, f, m);
    @(negedge clk);
    reqValid = 1'b0;
    note(busy === 1'b1, "R2 busy after acceptance", busy, 1);
    waitFree(f, dll);
  endtask

  initial begin
    int f, m, f2, m2;
    repeat (3) @(negedge clk);
    // R1 reset state
    note(busy === 1'b0, "R1 busy in reset", busy, 0);
    note(cmdValid === 1'b0, "R1 cmdValid in reset", cmdValid, 0);
    note(cmd === 2'd0, "R1 cmd in reset", cmd, 0);
    rstN = 1'b1;
    monOn = 1'b1;
    @(negedge clk);
    note(busy === 1'b0 && cmdValid === 1'b0, "R1 after reset", {busy, cmdValid}, 0);
    @(negedge clk);

    // R5 R6 R7: base register, all banks idle, burst opcode in low bits
    runOne(1'b0, 13'h0032, 1'b0, 4'b0000);
    @(negedge clk);
    // R3 R4 R6: extended register with one bank open
    runOne(1'b1, 13'h0002, 1'b0, 4'b0100);
    @(negedge clk);
    // R8: DLL reset with every bank open
    runOne(1'b0, 13'h0163, 1'b1, 4'b1111);
    @(negedge clk);
    // R8 R5: extended register, DLL reset, banks idle
    runOne(1'b1, 13'h1FFF, 1'b1, 4'b0000);

    // R2: request held high through busy with different fields; starts the edge busy falls
    present(1'b1, 13'h0021, 1'b0, 4'b0001, f, m);
    @(negedge clk);
    reqExt = 1'b0; reqOpcode = 13'h0AAA; reqDllReset = 1'b1; bankOpen = 4'b0000;
    waitFree(f, 1'b0);
    // second request held since before, accepted on this edge; bank status now idle (R2 R5)
    present(1'b0, 13'h0AAA, 1'b1, 4'b0000, f2, m2);
    @(negedge clk);
    reqValid = 1'b0;
    note(busy === 1'b1, "R2 held request accepted at release", busy, 1);
    waitFree(f2, 1'b1);

    repeat (4) @(negedge clk);
    note(expQ.size() == 0, "R9 all expected commands seen", expQ.size(), 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule